// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block turns the fast main clock into the 16x oversampling tick that a UART receiver and transmitter step on. The rate passes through three stages in a row. A prescaler sets the UART input clock to the main clock divided by an integer. A fractional stage then removes a share of the prescaler pulses, which slows the rate by the factor 1 + MULT/256. An integer baud divider finishes the job by dividing by its setting plus one.

Software picks the integer baud setting as ((input clock / 16) / baud) - 1. The fractional multiplier absorbs the remainder that the integer division leaves, so the average tick rate sits close to 16 times the target baud, for example 57600 baud. The fractional stage is active only when its denominator input holds all ones (256 steps). With any other value it passes every pulse through unchanged.

Any change on a configuration input restarts the whole chain, so the first tick under the new setting falls on a clean boundary.

Top module: `baud_tick_gen`

## Requirements
- R1: With the fractional stage bypassed and a baud setting of 0, the tick rate equals the main clock rate divided by the prescaler setting `pre_div`.
- R2: A prescaler setting of 0 stops the chain entirely, so `tick` stays low. This is also the state after reset, where every configuration input is taken as 0.
- R3: The baud divider emits one tick for every `baud_div` + 1 pulses it receives. With `pre_div` = 1 and the fractional stage bypassed, ticks are exactly `baud_div` + 1 cycles apart.
- R4: When `frac_den` is 8'hFF, the average tick rate is clk / (`pre_div` x (1 + `frac_mul`/256) x (`baud_div` + 1)). Over a long window the count stays within 2 ticks of this value.
- R5: When `frac_den` is 8'hFF, each pulse that passes the fractional stage adds `frac_mul` to an 8-bit accumulator. A carry out of the accumulator drops the next input pulse. With `frac_mul` = 128, exactly 2 of every 3 pulses pass.
- R6: When `frac_den` is any value other than 8'hFF, `frac_mul` has no effect and every prescaler pulse passes.
- R7: A change on any configuration input clears all counters and pulses in flight. With `pre_div` = 1 and the fractional stage bypassed, the first tick after the change shows on the 8th rising edge that follows the change when `baud_div` = 4. In general this is `baud_div` + 4 edges.
- R8: With a 30 MHz main clock, `pre_div` = 1, `baud_div` = 31, `frac_mul` = 4 and `frac_den` = 8'hFF, the tick rate is within 1% of 16 x 57600 Hz.
- R9: `tick` is low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_div | input | 8 | Prescaler setting; 0 gates the chain off |
| frac_mul | input | 8 | Fractional multiplier, added per passed pulse |
| frac_den | input | 8 | Fractional denominator; 8'hFF enables the stage |
| baud_div | input | 16 | Baud divider setting; divides by value + 1 |
| tick | output | 1 | One-cycle 16x oversampling pulse |

## Verification
The hardest case to reach is a configuration change that lands while the divider chain is part way through a count with pulses still in the pipeline. A stale pulse or a stale count would shift the first new tick by a few cycles, and a long-window rate check would never notice. The stimulus first waits for a tick under a slow setting. It then lets five more cycles pass and only then changes the baud setting. It counts edges to the first new tick and then to the one after it. Both distances are compared against exact values.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {FRAC_PASS = 1'b0, FRAC_SCALE = 1'b1} frac_mode_e;
endpackage

// File: rtl/bg_prediv.sv
module bg_prediv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] div,
  output logic         pulse
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || div == '0) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt >= div - W'(1)) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + W'(1);
      pulse <= 1'b0;
    end
  end

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !pulse); // R2
  AST_PREDIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && div > W'(1) && $stable(div)) |=> !pulse); // R1
endmodule

// File: rtl/bg_frac.sv
module bg_frac
  import baud_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          in_pulse,
  input  logic [FW-1:0] mul,
  input  logic [FW-1:0] den,
  output logic          out_pulse
);
  localparam logic [FW-1:0] FULL_SCALE = '1;

  frac_mode_e   mode;
  logic [FW-1:0] acc;
  logic          skip;
  logic [FW:0]   sum;

  assign mode = (den == FULL_SCALE) ? FRAC_SCALE : FRAC_PASS;
  assign sum  = {1'b0, acc} + {1'b0, mul};

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc       <= '0;
      skip      <= 1'b0;
      out_pulse <= 1'b0;
    end else if (!in_pulse) begin
      out_pulse <= 1'b0;
    end else if (mode == FRAC_PASS) begin
      out_pulse <= 1'b1;
    end else if (skip) begin
      skip      <= 1'b0;
      out_pulse <= 1'b0;
    end else begin
      acc       <= sum[FW-1:0];
      skip      <= sum[FW];
      out_pulse <= 1'b1;
    end
  end

  AST_FRAC_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> $past(in_pulse)); // R5
  AST_FRAC_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && in_pulse && mode == FRAC_SCALE && !restart) |=> !out_pulse); // R5
  AST_FRAC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse && mode == FRAC_PASS && !restart) |=> out_pulse); // R6
endmodule

// File: rtl/bg_bauddiv.sv
module bg_bauddiv #(
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          in_pulse,
  input  logic [BW-1:0] div,
  output logic          tick
);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (in_pulse) begin
      if (cnt >= div) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + BW'(1);
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick); // R3
  AST_TICK_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(in_pulse)); // R3
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int PDIV_W = 8,
  parameter int FRAC_W = 8,
  parameter int BDIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PDIV_W-1:0] pre_div,
  input  logic [FRAC_W-1:0] frac_mul,
  input  logic [FRAC_W-1:0] frac_den,
  input  logic [BDIV_W-1:0] baud_div,
  output logic              tick
);
  localparam int CFG_W = PDIV_W + 2 * FRAC_W + BDIV_W;

  logic [CFG_W-1:0] cfg_now, cfg_prev;
  logic             restart;
  logic             pre_pulse, frac_pulse;

  assign cfg_now = {pre_div, frac_mul, frac_den, baud_div};
  assign restart = (cfg_now != cfg_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_prev <= '0;
    else        cfg_prev <= cfg_now;
  end

  bg_prediv #(.W(PDIV_W)) u_prediv (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(pre_div), .pulse(pre_pulse)
  );

  bg_frac #(.FW(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_pulse(pre_pulse),
    .mul(frac_mul), .den(frac_den), .out_pulse(frac_pulse)
  );

  bg_bauddiv #(.BW(BDIV_W)) u_bauddiv (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_pulse(frac_pulse),
    .div(baud_div), .tick(tick)
  );

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !tick); // R9
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pre_div = '0;
  logic [7:0]  frac_mul = '0;
  logic [7:0]  frac_den = '0;
  logic [15:0] baud_div = '0;
  logic        tick;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    int    window;
    int    expect_cnt;
    int    tol;
  } item_t;

  item_t sb_q[$];
  bit    mon_done = 0;

  always #4 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .pre_div(pre_div), .frac_mul(frac_mul),
    .frac_den(frac_den), .baud_div(baud_div), .tick(tick)
  );

  task automatic check(string tag, int got, int exp_v, int tol);
    int d;
    n_checks++;
    d = got - exp_v;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d (tol %0d)", tag, got, exp_v, tol);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // Monitor: pops an expected item, counts ticks over its window, compares
  initial begin
    forever begin
      item_t it;
      int    got;
      wait (sb_q.size() > 0);
      it  = sb_q.pop_front();
      got = 0;
      for (int i = 0; i < it.window; i++) begin
        @(negedge clk);
        if (tick) got++;
      end
      check(it.tag, got, it.expect_cnt, it.tol);
      mon_done = 1;
    end
  end

  task automatic apply(int pd, int fm, int fd, int bd);
    @(negedge clk);
    pre_div  = 8'(pd);
    frac_mul = 8'(fm);
    frac_den = 8'(fd);
    baud_div = 16'(bd);
  endtask

  // Driver: program, settle, push expected count, wait for the monitor
  task automatic run_case(string tag, int pd, int fm, int fd, int bd,
                          int window, int expect_cnt, int tol);
    item_t it;
    apply(pd, fm, fd, bd);
    repeat (300) @(negedge clk);
    it.tag = tag; it.window = window; it.expect_cnt = expect_cnt; it.tol = tol;
    mon_done = 0;
    sb_q.push_back(it);
    wait (mon_done);
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    int got_ticks;
    repeat (3) @(negedge clk);
    check("R9 tick in reset", int'(tick), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 tick after reset", int'(tick), 0, 0);

    // R2: prescaler 0 gates everything off
    run_case("R2 gated", 0, 64, 255, 0, 2000, 0, 0);
    // R1: prescaler alone sets the rate
    run_case("R1 prescale 3", 3, 0, 0, 0, 3000, 1000, 1);
    run_case("R1 prescale 7", 7, 0, 0, 0, 3500, 500, 1);
    // R3: baud divider by value + 1
    run_case("R3 baud 7", 1, 0, 0, 7, 4000, 500, 1);
    // R6: multiplier ignored when denominator is not full scale
    run_case("R6 bypass den 80", 1, 200, 128, 3, 4000, 1000, 1);
    run_case("R6 bypass den FE", 2, 255, 254, 1, 4000, 1000, 1);
    // R5: mult 128 passes 2 of 3
    run_case("R5 two of three", 1, 128, 255, 0, 3000, 2000, 1);
    // R4: average fractional rate, 1/(2*1.25*5)
    run_case("R4 frac 64", 2, 64, 255, 4, 25000, 2000, 2);
    // R4 and R8: 57600 baud setup at 30 MHz main clock
    begin
      item_t it;
      apply(1, 4, 255, 31);
      repeat (300) @(negedge clk);
      got_ticks = 0;
      for (int i = 0; i < 60000; i++) begin
        @(negedge clk);
        if (tick) got_ticks++;
      end
      // R4 exact model: 60000*256/(260*32)
      check("R4 frac 4", got_ticks, (60000 * 256) / (260 * 32), 2);
      // R8: 16*57600/30e6 * 60000 = 1843.2, 1% = 18
      check("R8 57600 baud", got_ticks, 1843, 18);
      it.tag = "R4 frac 4 second window"; it.window = 8320;
      it.expect_cnt = 256; it.tol = 1;
      mon_done = 0;
      sb_q.push_back(it);
      wait (mon_done);
    end

    // R7: change the baud setting mid-count
    apply(1, 0, 0, 9);
    repeat (50) @(negedge clk);
    while (!tick) @(negedge clk);
    repeat (5) @(negedge clk);
    baud_div = 16'd4;
    k = 0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
    end while (!tick && k < 100);
    check("R7 first tick after change", k, 8, 0);
    k = 0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
    end while (!tick && k < 100);
    check("R3 interval after change", k, 5, 0);

    finish_run();
  end
endmodule